// File: doc/BRIEF.md
# Four-Channel Converter Serial Load Front End

This block is the digital input stage of a four-channel 12-bit converter. A 16-bit serial word is shifted in most significant bit first. The shift register has no free-running clock. It advances on every rising edge of the OR of the active-low select and the serial clock, so either pin can act as the shift clock while the other is held low.

The top two bits of the word name a channel. The next two bits are don't-care. The low twelve bits are straight-binary data. Each channel owns a level-sensitive holding register. While the load strobe is low, the register named by the live address bits is open and copies the live data bits. While the strobe is high, all four registers hold. An asynchronous reset forces every holding register to zero or to midscale, chosen by a pin, and leaves the shift register alone.

The outputs are the four register values, the decoded address, the shift register contents and a per-channel open indicator. The pins are plain control pins with no handshake.

Top module: `dac_serial_front`

## Requirements
- R1: Each rising edge of (cs_n OR sclk) shifts shreg_o left by one and places sdin in bit 0, so a 16-bit word arrives MSB first after 16 edges.
- R2: cs_n and sclk act the same way as the shift clock. Pin activity that leaves their OR unchanged does not alter shreg_o. A rise of cs_n while sclk is low is an edge and shifts one extra bit.
- R3: addr_o equals shreg_o[15:14]. Value 0 names channel A (chan_q[0]), 1 names B, 2 names C and 3 names D.
- R4: While load_n is low and rst_n is high, transp_o is one-hot at addr_o and the named channel equals shreg_o[11:0].
- R5: While load_n is high, transp_o is zero and no channel changes, even when new words are shifted in.
- R6: While rst_n is low, every channel reads 12'h000 if rst_mid is 0, or 12'h800 if rst_mid is 1, whatever load_n does. transp_o is zero during reset.
- R7: When rst_n rises with load_n high, every channel keeps its reset value.
- R8: rst_n has no effect on shreg_o. Words shift in normally during reset.
- R9: Shifting with load_n low moves the address as the bits move. Each channel named along the way takes the data present while it was named and keeps it once the address moves on.
- R10: Bits [13:12] of the word never reach any channel or the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Active-low select, ORed with sclk to form the shift clock |
| sclk | input | 1 | Serial clock, ORed with cs_n |
| sdin | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Low: the addressed channel is open |
| rst_n | input | 1 | Asynchronous reset of the channel registers, active low |
| rst_mid | input | 1 | Reset value select: 0 gives zero, 1 gives midscale |
| shreg_o | output | 16 | Shift register contents |
| addr_o | output | 2 | Live channel address |
| transp_o | output | 4 | Per-channel open indicator |
| chan_q | output | 4x12 | Channel register values, index 0 is A |

## Verification
The bench targets these cases:

- **Closing rise of cs_n.** A rise of cs_n with sclk low must add one bit. A design that sampled only sclk would leave the word unshifted.
- **Reset ordering.** Reset must override an open strobe, and the reset value must survive the release of reset. A design with a synchronous or priority-inverted reset would show the shifted data on a channel.
- **Shifting with the strobe open.** Earlier channels must keep the data they held when the address moved on. A design that let a closing channel see the next data word would show the wrong value there.
- **Don't-care bits.** Words with the pad bits set must not leak into the data or the address.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  localparam int DEF_DATA_W = 12;
  localparam int DEF_N_CH   = 4;
  localparam int DEF_PAD_W  = 2;

  function automatic logic [DEF_DATA_W-1:0] def_reset_code(input logic mid);
    return mid ? (DEF_DATA_W)'(1) << (DEF_DATA_W - 1) : '0;
  endfunction
endpackage

// File: rtl/dac_shifter.sv
module dac_shifter #(
  parameter int SR_W = 16
) (
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            sdin,
  output logic [SR_W-1:0] sr_q
);
  logic shift_clk;

  // Gated edge source: either pin clocks the register while the other is low.
  assign shift_clk = cs_n | sclk;

  always_ff @(posedge shift_clk) begin
    sr_q <= {sr_q[SR_W-2:0], sdin};
  end
endmodule

// File: rtl/dac_addr_dec.sv
module dac_addr_dec #(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              load_n,
  input  logic              rst_n,
  output logic [N_CH-1:0]   open_o
);
  for (genvar k = 0; k < N_CH; k++) begin : g_dec
    assign open_o[k] = rst_n && !load_n && (addr == (ADDR_W)'(k));
  end
endmodule

// File: rtl/dac_chan_latch.sv
module dac_chan_latch #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 2,
  parameter int IDX    = 0
) (
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rst_val,
  input  logic              load_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] q
);
  localparam logic [ADDR_W-1:0] MY_ADDR = (ADDR_W)'(IDX);

  // The address match and the data come from one snapshot of the shift
  // register, so a channel that loses the address keeps its older data.
  always_latch begin
    if (!rst_n) begin
      q <= rst_val;
    end else if (!load_n && (addr == MY_ADDR)) begin
      q <= data;
    end
  end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
  parameter  int DATA_W = dac_if_pkg::DEF_DATA_W,
  parameter  int N_CH   = dac_if_pkg::DEF_N_CH,
  parameter  int PAD_W  = dac_if_pkg::DEF_PAD_W,
  localparam int ADDR_W = $clog2(N_CH),
  localparam int SR_W   = ADDR_W + PAD_W + DATA_W
) (
  input  logic                         cs_n,
  input  logic                         sclk,
  input  logic                         sdin,
  input  logic                         load_n,
  input  logic                         rst_n,
  input  logic                         rst_mid,
  output logic [SR_W-1:0]              shreg_o,
  output logic [ADDR_W-1:0]            addr_o,
  output logic [N_CH-1:0]              transp_o,
  output logic [N_CH-1:0][DATA_W-1:0]  chan_q
);
  logic [DATA_W-1:0] rst_val;
  logic [DATA_W-1:0] live_data;

  assign rst_val   = {rst_mid, {(DATA_W-1){1'b0}}};
  assign live_data = shreg_o[DATA_W-1:0];
  assign addr_o    = shreg_o[SR_W-1 -: ADDR_W];

  dac_shifter #(.SR_W(SR_W)) u_shift (
    .cs_n (cs_n),
    .sclk (sclk),
    .sdin (sdin),
    .sr_q (shreg_o)
  );

  dac_addr_dec #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr   (addr_o),
    .load_n (load_n),
    .rst_n  (rst_n),
    .open_o (transp_o)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    dac_chan_latch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX(k)) u_lat (
      .rst_n   (rst_n),
      .rst_val (rst_val),
      .load_n  (load_n),
      .addr    (shreg_o[SR_W-1 -: ADDR_W]),
      .data    (live_data),
      .q       (chan_q[k])
    );
  end
endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk #(
  parameter  int DATA_W = 12,
  parameter  int N_CH   = 4,
  parameter  int PAD_W  = 2,
  localparam int ADDR_W = $clog2(N_CH),
  localparam int SR_W   = ADDR_W + PAD_W + DATA_W
) (
  input logic                        cs_n,
  input logic                        sclk,
  input logic                        sdin,
  input logic                        load_n,
  input logic                        rst_n,
  input logic                        rst_mid,
  input logic [SR_W-1:0]             shreg_o,
  input logic [ADDR_W-1:0]           addr_o,
  input logic [N_CH-1:0]             transp_o,
  input logic [N_CH-1:0][DATA_W-1:0] chan_q
);
  logic shclk;
  logic [1:0] n_edges = 2'd0;
  logic [N_CH-1:0][DATA_W-1:0] all_mid;

  assign shclk = cs_n | sclk;

  for (genvar k = 0; k < N_CH; k++) begin : g_mid
    assign all_mid[k] = {1'b1, {(DATA_W-1){1'b0}}};
  end

  always_ff @(posedge shclk) begin
    if (n_edges != 2'd2) n_edges <= n_edges + 2'd1;
  end

  a_r1_shift_order: assert property (@(posedge shclk) disable iff (!rst_n)
    (n_edges == 2'd2) |-> (shreg_o[SR_W-1:1] == $past(shreg_o[SR_W-2:0]) &&
                           shreg_o[0] == $past(sdin)));

  a_r4_onehot: assert property (@(posedge shclk) disable iff (!rst_n)
    $onehot0(transp_o));

  a_r5_closed: assert property (@(posedge shclk) disable iff (!rst_n)
    load_n |-> (transp_o == '0));

  a_r4_follow: assert property (@(posedge load_n) disable iff (!rst_n)
    chan_q[addr_o] == shreg_o[DATA_W-1:0]);

  a_r6_reset_value: assert property (@(posedge rst_n)
    chan_q == (rst_mid ? all_mid : '0));
endmodule

bind dac_serial_front dac_serial_front_chk #(
  .DATA_W(DATA_W), .N_CH(N_CH), .PAD_W(PAD_W)
) u_chk (
  .cs_n(cs_n), .sclk(sclk), .sdin(sdin), .load_n(load_n), .rst_n(rst_n),
  .rst_mid(rst_mid), .shreg_o(shreg_o), .addr_o(addr_o),
  .transp_o(transp_o), .chan_q(chan_q)
);

// File: tb/dac_serial_front_tb.sv
module dac_serial_front_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic cs_n = 1'b1, sclk = 1'b1, sdin = 1'b0, load_n = 1'b1;
  logic rst_n = 1'b0, rst_mid = 1'b1;
  logic [15:0] shreg_o;
  logic [1:0]  addr_o;
  logic [3:0]  transp_o;
  logic [3:0][11:0] chan_q;

  dac_serial_front u_dut (
    .cs_n(cs_n), .sclk(sclk), .sdin(sdin), .load_n(load_n), .rst_n(rst_n),
    .rst_mid(rst_mid), .shreg_o(shreg_o), .addr_o(addr_o),
    .transp_o(transp_o), .chan_q(chan_q)
  );

  int n_chk = 0, n_err = 0;
  logic [15:0] m_sr = '0;
  logic [11:0] m_ch [4];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [11:0] rv();
    return rst_mid ? 12'h800 : 12'h000;
  endfunction

  task automatic m_shift(input logic b);
    m_sr = {m_sr[14:0], b};
    if (!load_n && rst_n) m_ch[m_sr[15:14]] = m_sr[11:0];
  endtask

  task automatic set_ld(input logic v);
    load_n = v; tick();
    if (!v && rst_n) m_ch[m_sr[15:14]] = m_sr[11:0];
  endtask

  task automatic set_rst(input logic v);
    rst_n = v; tick();
    if (!v) for (int k = 0; k < 4; k++) m_ch[k] = rv();
  endtask

  task automatic cmp_chans(input string tag);
    for (int k = 0; k < 4; k++)
      chk(chan_q[k] === m_ch[k], tag, chan_q[k], m_ch[k]);
  endtask

  task automatic shift_sclk(input logic [15:0] w);
    cs_n = 1'b0; tick();
    for (int i = 15; i >= 0; i--) begin
      sclk = 1'b0; sdin = w[i]; tick();
      sclk = 1'b1; tick(); m_shift(w[i]);
    end
    cs_n = 1'b1; tick();
  endtask

  task automatic shift_cs(input logic [15:0] w);
    sclk = 1'b0; tick();
    for (int i = 15; i >= 0; i--) begin
      cs_n = 1'b0; sdin = w[i]; tick();
      cs_n = 1'b1; tick(); m_shift(w[i]);
    end
    sclk = 1'b1; tick();
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) m_ch[k] = 12'h800;
    tick(); tick();
    for (int k = 0; k < 4; k++) chk(chan_q[k] === 12'h800, "R6 midscale reset", chan_q[k], 12'h800);
    chk(transp_o === 4'b0, "R6 closed in reset", transp_o, 0);
    shift_sclk(16'hC5A3);
    chk(shreg_o === 16'hC5A3, "R8 shift during reset", shreg_o, 16'hC5A3);
    set_ld(1'b0);
    for (int k = 0; k < 4; k++) chk(chan_q[k] === 12'h800, "R6 reset beats load", chan_q[k], 12'h800);
    chk(transp_o === 4'b0, "R6 no open in reset", transp_o, 0);
    set_ld(1'b1);
    set_rst(1'b1);
    for (int k = 0; k < 4; k++) chk(chan_q[k] === 12'h800, "R7 keep after release", chan_q[k], 12'h800);
    chk(shreg_o === 16'hC5A3, "R8 shreg untouched", shreg_o, 16'hC5A3);
  endtask

  task automatic t_load_each();
    for (int k = 0; k < 4; k++) begin
      logic [11:0] d;
      d = 12'h3A0 ^ (12'(k) * 12'h155);
      shift_sclk({2'(k), 2'b11, d});
      chk(shreg_o === {2'(k), 2'b11, d}, "R1 word MSB first", shreg_o, {2'(k), 2'b11, d});
      chk(addr_o === 2'(k), "R3 address decode", addr_o, k);
      cmp_chans("R5 hold while shifting");
      set_ld(1'b0);
      chk(transp_o === 4'(1 << k), "R4 open indicator", transp_o, 1 << k);
      chk(chan_q[k] === d, "R4 follows data", chan_q[k], d);
      chk(chan_q[k] === d, "R10 pad bits ignored", chan_q[k], d);
      set_ld(1'b1);
      chk(transp_o === 4'b0, "R5 closed", transp_o, 0);
    end
    shift_sclk(16'h0FFF);
    cmp_chans("R5 no change with strobe high");
  endtask

  task automatic t_cs_clock();
    shift_cs(16'h9C3E);
    chk(shreg_o === 16'h9C3E, "R2 cs_n as clock", shreg_o, 16'h9C3E);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; sdin = 1'b1; tick();
      sclk = 1'b1; tick();
    end
    chk(shreg_o === 16'h9C3E, "R2 steady OR no shift", shreg_o, 16'h9C3E);
    sclk = 1'b0; tick();
    cs_n = 1'b0; sdin = 1'b1; tick();
    cs_n = 1'b1; tick(); m_shift(1'b1);
    chk(shreg_o === 16'h387D, "R2 extra edge on cs_n rise", shreg_o, 16'h387D);
    sclk = 1'b1; tick();
    cmp_chans("R5 after cs shifts");
  endtask

  task automatic t_corrupt();
    shift_sclk(16'h0ABC);
    set_ld(1'b0);
    chk(chan_q[0] === 12'hABC, "R4 ch A open", chan_q[0], 12'hABC);
    cs_n = 1'b0; tick();
    foreach (m_sr[i]) if (i < 4) begin
      logic b;
      b = (i == 3 || i == 1);
      sclk = 1'b0; sdin = b; tick();
      sclk = 1'b1; tick(); m_shift(b);
    end
    cs_n = 1'b1; tick();
    chk(shreg_o === 16'hABCA, "R9 word after moves", shreg_o, 16'hABCA);
    chk(chan_q[0] === 12'hAF2, "R9 ch A last value", chan_q[0], 12'hAF2);
    chk(chan_q[1] === 12'h5E5, "R9 ch B overwritten", chan_q[1], 12'h5E5);
    chk(chan_q[2] === 12'hBCA, "R9 ch C live", chan_q[2], 12'hBCA);
    cmp_chans("R9 model match");
    set_ld(1'b1);
  endtask

  task automatic t_reset_zero();
    rst_mid = 1'b0; tick();
    set_rst(1'b0);
    for (int k = 0; k < 4; k++) chk(chan_q[k] === 12'h000, "R6 zero reset", chan_q[k], 0);
    set_rst(1'b1);
    for (int k = 0; k < 4; k++) chk(chan_q[k] === 12'h000, "R7 zero kept", chan_q[k], 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_load_each();
    t_cs_clock();
    t_corrupt();
    t_reset_zero();
    finish_run();
  end
endmodule